// File: doc/BRIEF.md
# Halt Mode Sequencer

This block sequences the two sleep depths of a small microcontroller core. One halt request from the CPU is steered by a mode-select bit. When the bit is 1 the core goes into an active halt: the main oscillator and its real-time-clock counter keep running, and the CPU and peripheral clocks are gated off. When the bit is 0 the core goes into a deep halt, where the oscillator is gated off as well. On entry to either depth the controller clears the global interrupt mask, so an interrupt that is already pending wakes the core at once.

A wake-up always passes through a fixed startup wait of `DELAY` clock cycles, then a single release cycle. In that cycle the CPU is told either to service the waking interrupt or to fetch the reset vector. A wake-cause code records why the core woke and stays valid until the release cycle ends. Reset requests take priority over every interrupt. If the watchdog is running and the deep-halt depth is chosen, the halt request turns into a reset, because the watchdog could not be serviced during a deep halt. The active-halt depth suppresses that reset, since its timer interrupt bounds the time spent asleep.

Top module: `lp_halt_ctrl`

## Requirements
- R1: In the run state, a `halt_req` pulse with `rtc_sel`=1 moves the controller to active halt. With `rtc_sel`=0 and `wdog_on`=0 it moves the controller to deep halt. Both moves happen at the next clock edge.
- R2: Clock enables follow the state as below:
  - run and release: `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1.
  - deep halt: all three are 0.
  - active halt: only `osc_en` is 1.
  - startup wait: only `osc_en` is 1.
- R3: `imask` is 1 after reset. It is 0 from the first cycle of either halt state.
- R4: Wake sources depend on the depth:
  - Deep halt wakes on any bit of `ext_irq` or on `rst_req`. `rtc_irq` is ignored there.
  - Active halt wakes on `rtc_irq`, on an `ext_irq` bit whose `ACT_MASK` bit is 1, or on `rst_req`. The other `ext_irq` bits leave the state unchanged.
- R5: A wake source that is already active when a halt is entered causes the startup wait from the first cycle in the halt state. The halt state then lasts one cycle.
- R6: The startup wait lasts exactly `DELAY` cycles (default 4096). It is followed by exactly one release cycle, and then by the run state.
- R7: In the release cycle exactly one of `service_irq` and `fetch_rst_vec` is 1. `fetch_rst_vec` is 1 when the wake cause is reset, and `service_irq` is 1 otherwise. Both are 0 in every other state.
- R8: A `halt_req` with `rtc_sel`=0 and `wdog_on`=1 does not halt. `wdog_rst` pulses for one cycle after the request, and the controller enters the startup wait with cause reset. With `rtc_sel`=1, `wdog_rst` stays 0.
- R9: A release that services an interrupt pulses `imask_set` and sets `imask` to 1. A later `isr_done` in the run state restores the value `imask` held before the release (0 after a halt). A release to the reset vector sets `imask` to 1 without pulsing `imask_set`.
- R10: `wake_cause` uses the codes 0 none, 1 timer interrupt, 2 external interrupt, 3 reset. The priority is reset, then timer, then external. The code is loaded on entry to the startup wait, holds through the release cycle, and returns to 0 in the run state.
- R11: A `rst_req` during the startup wait, or in the run state, restarts the full wait with cause reset.
- R12: `state_o` encodes the state as 0 run, 1 deep halt, 2 active halt, 3 startup wait, 4 release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request pulse from the CPU |
| rtc_sel | input | 1 | Depth select: 1 active halt, 0 deep halt |
| wdog_on | input | 1 | Watchdog is running |
| rtc_irq | input | 1 | Real-time-clock interrupt |
| ext_irq | input | N_EXT | External interrupt lines |
| rst_req | input | 1 | Reset wake request |
| isr_done | input | 1 | Return from the interrupt routine |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| imask | output | 1 | Global interrupt mask bit |
| imask_set | output | 1 | Mask-set pulse at service start |
| service_irq | output | 1 | Release: service the interrupt |
| fetch_rst_vec | output | 1 | Release: fetch the reset vector |
| wdog_rst | output | 1 | Reset pulse for a halt under the watchdog |
| wake_cause | output | 2 | Recorded wake cause |
| state_o | output | 3 | Current state code |

## Verification
A wrong state shows up on `state_o` and on the three clock enables on the very next cycle. A wake source that is qualified wrongly is seen the cycle after the stimulus, either as a halt that never ends or as a startup wait that should not have begun. An off-by-one in the wait counter moves the release pulse by one cycle, which shows only after `DELAY` cycles. An error in saving or restoring the mask stays hidden until the cycle after `isr_done` or after the release. For these reasons every output is compared with the reference model on every clock, rather than only at the ends of each scenario.

// File: rtl/lp_halt_pkg.sv
// Shared types for the halt-mode sequencer.
// Assumes: the state codes are visible on a port and are fixed by the brief.
package lp_halt_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_HALT     = 3'd1,
        ST_ACT_HALT = 3'd2,
        ST_WAKE_DLY = 3'd3,
        ST_RELEASE  = 3'd4
    } pm_state_e;

    typedef enum logic [1:0] {
        WC_NONE = 2'd0,
        WC_RTC  = 2'd1,
        WC_EXT  = 2'd2,
        WC_RST  = 2'd3
    } wake_cause_e;
endpackage

// File: rtl/lp_wake_qual.sv
// Wake-source qualifier. Decides, for the current halt depth, whether a
// wake-up is requested and which cause wins (reset > timer > external).
// Assumes: in_halt and in_act are never both 1.
module lp_wake_qual
    import lp_halt_pkg::*;
#(
    parameter int unsigned N_EXT    = 4,
    parameter logic [N_EXT-1:0] ACT_MASK = '1
) (
    input  logic             in_halt,
    input  logic             in_act,
    input  logic             rst_req,
    input  logic             rtc_irq,
    input  logic [N_EXT-1:0] ext_irq,
    output logic             wake,
    output wake_cause_e      cause
);
    logic [N_EXT-1:0] act_ok;

    // One qualifying gate per external line for the active-halt depth.
    for (genvar i = 0; i < N_EXT; i++) begin : g_qual
        assign act_ok[i] = ext_irq[i] & ACT_MASK[i];
    end

    logic ext_deep;
    logic ext_act;
    assign ext_deep = |ext_irq;
    assign ext_act  = |act_ok;

    // Wake decision and cause priority for the current depth.
    always_comb begin
        wake = rst_req | (in_halt & ext_deep) | (in_act & (rtc_irq | ext_act));
        if (rst_req)
            cause = WC_RST;
        else if (in_act && rtc_irq)
            cause = WC_RTC;
        else
            cause = WC_EXT;
    end
endmodule

// File: rtl/lp_start_timer.sv
// Startup-delay counter. Counts cycles while run is high; done is high in
// the last of DELAY cycles. restart loads zero and overrides run.
// Assumes: DELAY >= 2.
module lp_start_timer #(
    parameter int unsigned DELAY = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + CW'(1);
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/lp_clk_map.sv
// Clock-enable decoder: maps the sequencer state to CPU, peripheral and
// oscillator enables. Assumes: unknown codes are treated as run.
module lp_clk_map
    import lp_halt_pkg::*;
(
    input  pm_state_e st,
    output logic      cpu_en,
    output logic      per_en,
    output logic      osc_en
);
    // Per-state enable table.
    always_comb begin
        unique case (st)
            ST_HALT:     begin cpu_en = 1'b0; per_en = 1'b0; osc_en = 1'b0; end
            ST_ACT_HALT: begin cpu_en = 1'b0; per_en = 1'b0; osc_en = 1'b1; end
            ST_WAKE_DLY: begin cpu_en = 1'b0; per_en = 1'b0; osc_en = 1'b1; end
            default:     begin cpu_en = 1'b1; per_en = 1'b1; osc_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/lp_halt_ctrl.sv
// Halt-mode sequencer top. Steers a halt request into deep or active halt,
// gates clocks, clears/sets the interrupt mask, runs the startup wait and
// issues the release pulse. Assumes: halt_req and isr_done are single-cycle
// pulses from the CPU; rst_req is synchronous to clk.
module lp_halt_ctrl
    import lp_halt_pkg::*;
#(
    parameter int unsigned      N_EXT    = 4,
    parameter logic [N_EXT-1:0] ACT_MASK = 4'b0011,
    parameter int unsigned      DELAY    = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             rtc_sel,
    input  logic             wdog_on,
    input  logic             rtc_irq,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             rst_req,
    input  logic             isr_done,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             imask,
    output logic             imask_set,
    output logic             service_irq,
    output logic             fetch_rst_vec,
    output logic             wdog_rst,
    output logic [1:0]       wake_cause,
    output logic [2:0]       state_o
);
    pm_state_e   st_q, st_d;
    wake_cause_e cause_q, cause_d;
    wake_cause_e wq_cause;
    logic        wq_wake;
    logic        tmr_restart, tmr_done;
    logic        enter_halt, wd_fire;
    logic        imask_q, saved_q, wdog_q;

    lp_wake_qual #(.N_EXT(N_EXT), .ACT_MASK(ACT_MASK)) u_qual (
        .in_halt (st_q == ST_HALT),
        .in_act  (st_q == ST_ACT_HALT),
        .rst_req (rst_req),
        .rtc_irq (rtc_irq),
        .ext_irq (ext_irq),
        .wake    (wq_wake),
        .cause   (wq_cause)
    );

    lp_start_timer #(.DELAY(DELAY)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (st_q == ST_WAKE_DLY),
        .done    (tmr_done)
    );

    lp_clk_map u_clk (
        .st     (st_q),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en),
        .osc_en (osc_en)
    );

    // Next-state, wake-cause and timer-restart decision.
    always_comb begin
        st_d        = st_q;
        cause_d     = cause_q;
        tmr_restart = 1'b0;
        enter_halt  = 1'b0;
        wd_fire     = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (rst_req) begin
                    st_d = ST_WAKE_DLY; cause_d = WC_RST; tmr_restart = 1'b1;
                end else if (halt_req) begin
                    if (rtc_sel) begin
                        st_d = ST_ACT_HALT; enter_halt = 1'b1;
                    end else if (wdog_on) begin
                        st_d = ST_WAKE_DLY; cause_d = WC_RST;
                        tmr_restart = 1'b1; wd_fire = 1'b1;
                    end else begin
                        st_d = ST_HALT; enter_halt = 1'b1;
                    end
                end
            end
            ST_HALT, ST_ACT_HALT: begin
                if (wq_wake) begin
                    st_d = ST_WAKE_DLY; cause_d = wq_cause; tmr_restart = 1'b1;
                end
            end
            ST_WAKE_DLY: begin
                if (rst_req) begin
                    cause_d = WC_RST; tmr_restart = 1'b1;
                end else if (tmr_done) begin
                    st_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (rst_req) begin
                    st_d = ST_WAKE_DLY; cause_d = WC_RST; tmr_restart = 1'b1;
                end else begin
                    st_d = ST_RUN; cause_d = WC_NONE;
                end
            end
            default: begin
                st_d = ST_RUN; cause_d = WC_NONE;
            end
        endcase
    end

    // State, cause and watchdog-reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cause_q <= WC_NONE;
            wdog_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            cause_q <= cause_d;
            wdog_q  <= wd_fire;
        end
    end

    // Interrupt mask: clear on halt entry, set at release, restore on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= 1'b1;
            saved_q <= 1'b1;
        end else if (enter_halt) begin
            imask_q <= 1'b0;
        end else if (st_q == ST_RELEASE) begin
            if (cause_q != WC_RST)
                saved_q <= imask_q;
            imask_q <= 1'b1;
        end else if (st_q == ST_RUN && isr_done) begin
            imask_q <= saved_q;
        end
    end

    assign imask         = imask_q;
    assign service_irq   = (st_q == ST_RELEASE) && (cause_q != WC_RST);
    assign imask_set     = (st_q == ST_RELEASE) && (cause_q != WC_RST);
    assign fetch_rst_vec = (st_q == ST_RELEASE) && (cause_q == WC_RST);
    assign wdog_rst      = wdog_q;
    assign wake_cause    = cause_q;
    assign state_o       = st_q;

    // R2
    deep_halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |-> !(cpu_clk_en || per_clk_en || osc_en));

    // R2
    act_halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACT_HALT) |-> (osc_en && !cpu_clk_en && !per_clk_en));

    // R3
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && halt_req && !rst_req && (rtc_sel || !wdog_on))
        |=> (!imask && (state_o == 3'd1 || state_o == 3'd2)));

    // R4
    act_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACT_HALT && !rst_req && !rtc_irq && ((ext_irq & ACT_MASK) == '0))
        |=> (st_q == ST_ACT_HALT));

    // R6
    release_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RELEASE && !rst_req) |=> (st_q == ST_RUN && wake_cause == 2'd0));

    // R7
    release_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RELEASE) |-> ($countones({service_irq, fetch_rst_vec}) == 1));

    // R8
    wdog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (st_q == ST_WAKE_DLY || st_q == ST_RELEASE) && !$past(rtc_sel));

    // R11
    rst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAKE_DLY && rst_req) |=> (st_q == ST_WAKE_DLY && cause_q == WC_RST));
endmodule

// File: tb/lp_halt_ctrl_tb.sv
module lp_halt_ctrl_tb;
    localparam int N_EXT = 4;
    localparam logic [N_EXT-1:0] MASK = 4'b0011;
    localparam int DLY = 4096;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, halt_req = 1'b0, rtc_sel = 1'b0, wdog_on = 1'b0;
    logic rtc_irq = 1'b0, rst_req = 1'b0, isr_done = 1'b0;
    logic [N_EXT-1:0] ext_irq = '0;
    logic cpu_clk_en, per_clk_en, osc_en, imask, imask_set;
    logic service_irq, fetch_rst_vec, wdog_rst;
    logic [1:0] wake_cause;
    logic [2:0] state_o;

    lp_halt_ctrl #(.N_EXT(N_EXT), .ACT_MASK(MASK), .DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .rtc_sel(rtc_sel),
        .wdog_on(wdog_on), .rtc_irq(rtc_irq), .ext_irq(ext_irq),
        .rst_req(rst_req), .isr_done(isr_done), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .imask(imask),
        .imask_set(imask_set), .service_irq(service_irq),
        .fetch_rst_vec(fetch_rst_vec), .wdog_rst(wdog_rst),
        .wake_cause(wake_cause), .state_o(state_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int m_st = 0, m_cnt = 0, m_cause = 0, m_imask = 1, m_saved = 1, m_wd = 0;
    bit started = 0;

    always @(posedge clk) begin
        int ns;
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cause = 0; m_imask = 1; m_saved = 1; m_wd = 0;
        end else begin
            ns = m_st;
            m_wd = 0;
            case (m_st)
                0: if (rst_req) begin ns = 3; m_cnt = 0; m_cause = 3; end
                   else if (halt_req) begin
                       if (rtc_sel) begin ns = 2; m_imask = 0; end
                       else if (wdog_on) begin ns = 3; m_cnt = 0; m_cause = 3; m_wd = 1; end
                       else begin ns = 1; m_imask = 0; end
                   end else if (isr_done) m_imask = m_saved;
                1: if (rst_req) begin ns = 3; m_cnt = 0; m_cause = 3; end
                   else if (ext_irq != 0) begin ns = 3; m_cnt = 0; m_cause = 2; end
                2: if (rst_req) begin ns = 3; m_cnt = 0; m_cause = 3; end
                   else if (rtc_irq) begin ns = 3; m_cnt = 0; m_cause = 1; end
                   else if ((ext_irq & MASK) != 0) begin ns = 3; m_cnt = 0; m_cause = 2; end
                3: if (rst_req) begin m_cnt = 0; m_cause = 3; end
                   else if (m_cnt == DLY - 1) ns = 4;
                   else m_cnt++;
                4: begin
                    if (m_cause != 3) m_saved = m_imask;
                    m_imask = 1;
                    if (rst_req) begin ns = 3; m_cnt = 0; m_cause = 3; end
                    else begin ns = 0; m_cause = 0; end
                end
                default: ns = 0;
            endcase
            m_st = ns;
        end
    end

    // Full comparison against the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            check("R12 state", int'(state_o), m_st);
            check("R2 cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0 || m_st == 4));
            check("R2 per_clk_en", int'(per_clk_en), int'(m_st == 0 || m_st == 4));
            check("R2 osc_en", int'(osc_en), int'(m_st != 1));
            check("R3 imask", int'(imask), m_imask);
            check("R7 service_irq", int'(service_irq), int'(m_st == 4 && m_cause != 3));
            check("R7 fetch_rst_vec", int'(fetch_rst_vec), int'(m_st == 4 && m_cause == 3));
            check("R9 imask_set", int'(imask_set), int'(m_st == 4 && m_cause != 3));
            check("R8 wdog_rst", int'(wdog_rst), m_wd);
            check("R10 wake_cause", int'(wake_cause), m_cause);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_pulse(logic sel);
        rtc_sel = sel; halt_req = 1'b1;
        step(1);
        halt_req = 1'b0;
    endtask

    // Count cycles in the startup wait, then check the release and the run state.
    task automatic finish_wake(int exp_cause);
        int n = 0;
        while (state_o == 3'd3 && n < DLY + 10) begin
            n++;
            step(1);
        end
        check("R6 wait length", n, DLY);
        check("R6 release state", int'(state_o), 4);
        check("R7 release kind", int'(fetch_rst_vec), int'(exp_cause == 3));
        step(1);
        check("R6 back to run", int'(state_o), 0);
    endtask

    initial begin
        step(3);
        check("R3 reset imask", int'(imask), 1);
        check("R12 reset state", int'(state_o), 0);
        check("R2 reset clocks", int'({cpu_clk_en, per_clk_en, osc_en}), 7);
        rst_n = 1'b1;
        step(2);

        // Deep halt: timer interrupt ignored, external line wakes.
        halt_pulse(1'b0);
        check("R1 deep halt", int'(state_o), 1);
        check("R3 mask cleared", int'(imask), 0);
        rtc_irq = 1'b1; step(1); rtc_irq = 1'b0;
        check("R4 rtc ignored in deep halt", int'(state_o), 1);
        step(3);
        ext_irq = 4'b1000; step(1); ext_irq = '0;
        check("R10 ext cause", int'(wake_cause), 2);
        finish_wake(2);
        check("R9 mask set after service", int'(imask), 1);
        isr_done = 1'b1; step(1); isr_done = 1'b0;
        check("R9 mask restored", int'(imask), 0);

        // Active halt: unmasked line ignored, masked-in line wakes.
        halt_pulse(1'b1);
        check("R1 active halt", int'(state_o), 2);
        check("R2 osc on in active halt", int'(osc_en), 1);
        ext_irq = 4'b0100; step(2); ext_irq = '0;
        check("R4 line 2 ignored", int'(state_o), 2);
        ext_irq = 4'b0010; step(1); ext_irq = '0;
        check("R4 line 1 wakes", int'(state_o), 3);
        finish_wake(2);

        // Active halt: timer interrupt wakes.
        halt_pulse(1'b1);
        step(5);
        rtc_irq = 1'b1; step(1); rtc_irq = 1'b0;
        check("R10 rtc cause", int'(wake_cause), 1);
        finish_wake(1);

        // Simultaneous sources: reset wins.
        halt_pulse(1'b1);
        rtc_irq = 1'b1; ext_irq = 4'b0001; rst_req = 1'b1; step(1);
        rtc_irq = 1'b0; ext_irq = '0; rst_req = 1'b0;
        check("R10 reset priority", int'(wake_cause), 3);
        finish_wake(3);
        check("R9 mask after reset vector", int'(imask), 1);

        // Pending interrupt at entry wakes at once.
        ext_irq = 4'b0001;
        halt_pulse(1'b1);
        check("R5 entered active halt", int'(state_o), 2);
        step(1);
        ext_irq = '0;
        check("R5 immediate wake", int'(state_o), 3);
        finish_wake(2);

        // Watchdog with deep halt selected: reset instead of halt.
        wdog_on = 1'b1;
        halt_pulse(1'b0);
        check("R8 wdog reset pulse", int'(wdog_rst), 1);
        check("R8 no halt", int'(state_o), 3);
        step(100);
        rst_req = 1'b1; step(1); rst_req = 1'b0;
        check("R11 restart cause", int'(wake_cause), 3);
        finish_wake(3);

        // Watchdog with active halt selected: no reset.
        halt_pulse(1'b1);
        check("R8 active halt allowed", int'(state_o), 2);
        step(2);
        check("R8 no wdog reset", int'(wdog_rst), 0);
        rtc_irq = 1'b1; step(1); rtc_irq = 1'b0;
        finish_wake(1);
        wdog_on = 1'b0;

        // Reset request beats a halt request in the run state.
        rst_req = 1'b1; halt_req = 1'b1; rtc_sel = 1'b1; step(1);
        rst_req = 1'b0; halt_req = 1'b0;
        check("R11 reset from run", int'(state_o), 3);
        check("R10 reset over halt", int'(wake_cause), 3);
        finish_wake(3);

        step(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule